// File: doc/BRIEF.md
# Four-Queue Circular Pointer Manager

This block keeps the head and tail pointers of four circular word queues that share one memory region. The queues sit back to back: queue 0 (inbound free) starts at a 1 MB-aligned base, and queues 1 (inbound post), 2 (outbound post) and 3 (outbound free) follow at one, two and three queue sizes above it. The queue size is a programmable multiple of 16 KB. Every pointer is a full byte address that steps by one 4-byte word and wraps back to the start of its own queue's window.

Two request ports, one for the local processor and one for the host, ask for a push or a pop on a named queue. Each queue has a fixed producer side and a fixed consumer side. For an accepted request the block returns an acknowledge in the same cycle, together with the memory address that the requester should access: the head for a push, the tail for a pop. The pointer then advances on the next clock edge. The memory itself lives outside the block. Software sets up a control word, a base word and all eight pointers through a simple write port. The block reports per-queue empty, full and sticky overflow status, and a pending flag for the inbound post queue.

Top module: `cq_pointer_mgr`

## Requirements
- R1: After reset all eight pointers, the control word and the base are zero, no request is acknowledged, every queue reads empty, and no full, overflow or pending flag is set.
- R2: A write with select 0 loads the control word: bit 0 is enable and bits 5:1 are the size code. Select 1 loads the base, of which only bits 31:20 are kept. Select 8+q loads the head of queue q and select 12+q loads its tail.
- R3: The queue size is the size code times 16384 bytes, and queue q (0 inbound free, 1 inbound post, 2 outbound post, 3 outbound free) occupies the window that starts at base + q×size.
- R4: An accepted push acknowledges in the same cycle, returns the queue's current head as the access address, and advances the head by 4 on the next edge.
- R5: An accepted pop acknowledges in the same cycle, returns the queue's current tail as the access address, and advances the tail by 4 on the next edge.
- R6: A pointer at the last word of its window wraps to the start of that window when it advances.
- R7: A queue is empty when its head equals its tail. The pending output is high exactly while queue 1 is not empty.
- R8: A queue is full when its advanced head would equal its tail. A push to a full queue is not acknowledged, leaves the pointers unchanged and sets that queue's sticky overflow flag. A write of the control word clears all overflow flags.
- R9: A pop from an empty queue is not acknowledged and leaves both pointers unchanged.
- R10: While the enable bit is 0 or the size code is 0, every request is ignored: no acknowledge, and no pointer or flag changes.
- R11: The processor port may push queues 0 and 2 and pop queues 1 and 3. The host port may push queues 1 and 3 and pop queues 0 and 2. A request in the other direction is ignored.
- R12: A direct pointer write takes effect on the next edge and sets the empty and full status from the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 4 | Configuration register select |
| cfgWrData | input | 32 | Configuration write data |
| cpuReq | input | 1 | Processor-side request |
| cpuPush | input | 1 | Processor request is a push (1) or a pop (0) |
| cpuQ | input | 2 | Processor request queue index |
| hostReq | input | 1 | Host-side request |
| hostPush | input | 1 | Host request is a push (1) or a pop (0) |
| hostQ | input | 2 | Host request queue index |
| cpuAck | output | 1 | Processor request accepted this cycle |
| cpuAddr | output | 32 | Memory address for the processor access |
| hostAck | output | 1 | Host request accepted this cycle |
| hostAddr | output | 32 | Memory address for the host access |
| qEmpty | output | 4 | Per-queue empty status |
| qFull | output | 4 | Per-queue full status |
| ovfFlag | output | 4 | Per-queue sticky overflow flag |
| postPending | output | 1 | Inbound post queue holds at least one word |
| headPtrs | output | 128 | Head pointers, queue q in bits 32q+31:32q |
| tailPtrs | output | 128 | Tail pointers, queue q in bits 32q+31:32q |

## Verification
On every cycle the bound checker makes sure of four things. An acknowledge only answers a request in the permitted direction. A disabled block or a zero size code never acknowledges. Pops of empty queues and pushes to full queues are refused, and a refused pop leaves the tail untouched. Overflow flags only clear through a control write, and an accepted push always moves a head. The window layout, the masking of the base, the exact wrap target and the access addresses depend on the programmed size and base. Only the bench scenarios show those: they program several sizes, place pointers at window ends and compare every returned address and pointer against values worked out by hand.

// File: rtl/cqm_pkg.sv
package cqm_pkg;
  localparam int NUM_Q   = 4;
  localparam int ADDR_W  = 32;
  localparam int QIDX_W  = $clog2(NUM_Q);
  localparam int SEL_W   = 4;

  localparam logic [SEL_W-1:0] SEL_CTRL  = 4'd0;
  localparam logic [SEL_W-1:0] SEL_BASE  = 4'd1;
  localparam logic [SEL_W-1:0] SEL_HEAD0 = 4'd8;
  localparam logic [SEL_W-1:0] SEL_TAIL0 = 4'd12;

  typedef logic [ADDR_W-1:0] addr_t;

  // strobes from control to datapath, one bit per queue
  typedef struct packed {
    logic [NUM_Q-1:0] headAdv;
    logic [NUM_Q-1:0] tailAdv;
    logic [NUM_Q-1:0] ovfSet;
  } strobe_t;
endpackage

// File: rtl/cqm_dpath.sv
module cqm_dpath
  import cqm_pkg::*;
#(
  parameter int SIZE_SHIFT = 14,
  parameter int BASE_LSB   = 20,
  parameter int CODE_W     = 5,
  parameter int STEP       = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWrEn,
  input  logic [SEL_W-1:0]         cfgSel,
  input  logic [ADDR_W-1:0]        cfgWrData,
  input  strobe_t                  strb,
  output addr_t [NUM_Q-1:0]        headQ,
  output addr_t [NUM_Q-1:0]        tailQ,
  output logic  [NUM_Q-1:0]        emptyQ,
  output logic  [NUM_Q-1:0]        fullQ,
  output logic  [NUM_Q-1:0]        ovfQ,
  output logic                     opEnable,
  output logic  [CODE_W:0]         ctrlWord
);
  logic [CODE_W:0]            ctrlReg;
  logic [ADDR_W-1:BASE_LSB]   baseHi;
  addr_t                      sizeBytes;
  addr_t                      baseAddr;
  logic                       ctrlWrite;

  assign ctrlWrite = cfgWrEn && (cfgSel == SEL_CTRL);
  assign sizeBytes = addr_t'(ctrlReg[CODE_W:1]) << SIZE_SHIFT;
  assign baseAddr  = {baseHi, {BASE_LSB{1'b0}}};
  assign opEnable  = ctrlReg[0] && (ctrlReg[CODE_W:1] != '0);
  assign ctrlWord  = ctrlReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      baseHi  <= '0;
    end else if (cfgWrEn) begin
      if (cfgSel == SEL_CTRL) ctrlReg <= cfgWrData[CODE_W:0];
      if (cfgSel == SEL_BASE) baseHi  <= cfgWrData[ADDR_W-1:BASE_LSB];
    end
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    localparam logic [SEL_W-1:0] SEL_H = SEL_HEAD0 + SEL_W'(q);
    localparam logic [SEL_W-1:0] SEL_T = SEL_TAIL0 + SEL_W'(q);
    addr_t headR, tailR, qStart, qEnd, headInc, tailInc, headNext, tailNext;
    logic  ovfR;

    assign qStart   = baseAddr + addr_t'(q) * sizeBytes;
    assign qEnd     = qStart + sizeBytes;
    assign headInc  = headR + addr_t'(STEP);
    assign tailInc  = tailR + addr_t'(STEP);
    assign headNext = (headInc == qEnd) ? qStart : headInc;
    assign tailNext = (tailInc == qEnd) ? qStart : tailInc;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        headR <= '0;
        tailR <= '0;
        ovfR  <= 1'b0;
      end else begin
        if (cfgWrEn && cfgSel == SEL_H) headR <= cfgWrData;
        else if (strb.headAdv[q])       headR <= headNext;
        if (cfgWrEn && cfgSel == SEL_T) tailR <= cfgWrData;
        else if (strb.tailAdv[q])       tailR <= tailNext;
        if (ctrlWrite)                  ovfR  <= 1'b0;
        else if (strb.ovfSet[q])        ovfR  <= 1'b1;
      end
    end

    assign headQ[q]  = headR;
    assign tailQ[q]  = tailR;
    assign emptyQ[q] = (headR == tailR);
    assign fullQ[q]  = (headNext == tailR);
    assign ovfQ[q]   = ovfR;
  end
endmodule

// File: rtl/cqm_ctrl.sv
module cqm_ctrl
  import cqm_pkg::*;
(
  input  logic               cpuReq,
  input  logic               cpuPush,
  input  logic [QIDX_W-1:0]  cpuQ,
  input  logic               hostReq,
  input  logic               hostPush,
  input  logic [QIDX_W-1:0]  hostQ,
  input  logic               opEnable,
  input  addr_t [NUM_Q-1:0]  headQ,
  input  addr_t [NUM_Q-1:0]  tailQ,
  input  logic  [NUM_Q-1:0]  emptyQ,
  input  logic  [NUM_Q-1:0]  fullQ,
  output strobe_t            strb,
  output logic               cpuAck,
  output addr_t              cpuAddr,
  output logic               hostAck,
  output addr_t              hostAddr
);
  localparam int SIDES = 2;

  logic [SIDES-1:0]              reqS, pushS, ackS;
  logic [SIDES-1:0][QIDX_W-1:0]  qS;
  addr_t [SIDES-1:0]             addrS;

  assign reqS  = {hostReq, cpuReq};
  assign pushS = {hostPush, cpuPush};
  assign qS    = {hostQ, cpuQ};

  // side 0 produces into even queues, side 1 into odd queues
  always_comb begin
    strb = '0;
    ackS = '0;
    for (int s = 0; s < SIDES; s++) begin
      logic legal;
      legal    = (pushS[s] == (qS[s][0] == (s == 1)));
      addrS[s] = pushS[s] ? headQ[qS[s]] : tailQ[qS[s]];
      if (reqS[s] && opEnable && legal) begin
        if (pushS[s]) begin
          if (fullQ[qS[s]]) begin
            strb.ovfSet[qS[s]] = 1'b1;
          end else begin
            strb.headAdv[qS[s]] = 1'b1;
            ackS[s] = 1'b1;
          end
        end else if (!emptyQ[qS[s]]) begin
          strb.tailAdv[qS[s]] = 1'b1;
          ackS[s] = 1'b1;
        end
      end
    end
  end

  assign cpuAck   = ackS[0];
  assign hostAck  = ackS[1];
  assign cpuAddr  = addrS[0];
  assign hostAddr = addrS[1];
endmodule

// File: rtl/cq_pointer_mgr.sv
module cq_pointer_mgr
  import cqm_pkg::*;
#(
  parameter int SIZE_SHIFT = 14,
  parameter int BASE_LSB   = 20,
  parameter int CODE_W     = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWrEn,
  input  logic [SEL_W-1:0]          cfgSel,
  input  logic [ADDR_W-1:0]         cfgWrData,
  input  logic                      cpuReq,
  input  logic                      cpuPush,
  input  logic [QIDX_W-1:0]         cpuQ,
  input  logic                      hostReq,
  input  logic                      hostPush,
  input  logic [QIDX_W-1:0]         hostQ,
  output logic                      cpuAck,
  output logic [ADDR_W-1:0]         cpuAddr,
  output logic                      hostAck,
  output logic [ADDR_W-1:0]         hostAddr,
  output logic [NUM_Q-1:0]          qEmpty,
  output logic [NUM_Q-1:0]          qFull,
  output logic [NUM_Q-1:0]          ovfFlag,
  output logic                      postPending,
  output logic [NUM_Q*ADDR_W-1:0]   headPtrs,
  output logic [NUM_Q*ADDR_W-1:0]   tailPtrs
);
  strobe_t             strb;
  addr_t [NUM_Q-1:0]   headQ, tailQ;
  logic                opEnable;
  logic [CODE_W:0]     ctrlWord;

  cqm_dpath #(
    .SIZE_SHIFT(SIZE_SHIFT), .BASE_LSB(BASE_LSB), .CODE_W(CODE_W), .STEP(4)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .strb(strb), .headQ(headQ), .tailQ(tailQ),
    .emptyQ(qEmpty), .fullQ(qFull), .ovfQ(ovfFlag), .opEnable(opEnable),
    .ctrlWord(ctrlWord)
  );

  cqm_ctrl u_ctrl (
    .cpuReq(cpuReq), .cpuPush(cpuPush), .cpuQ(cpuQ),
    .hostReq(hostReq), .hostPush(hostPush), .hostQ(hostQ),
    .opEnable(opEnable), .headQ(headQ), .tailQ(tailQ),
    .emptyQ(qEmpty), .fullQ(qFull), .strb(strb),
    .cpuAck(cpuAck), .cpuAddr(cpuAddr), .hostAck(hostAck), .hostAddr(hostAddr)
  );

  assign headPtrs    = headQ;
  assign tailPtrs    = tailQ;
  assign postPending = !qEmpty[1];
endmodule

// File: rtl/cq_pointer_mgr_chk.sv
module cq_pointer_mgr_chk
  import cqm_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     cfgWrEn,
  input logic [SEL_W-1:0]         cfgSel,
  input logic                     cpuReq,
  input logic                     cpuPush,
  input logic [QIDX_W-1:0]        cpuQ,
  input logic                     hostReq,
  input logic                     hostPush,
  input logic [QIDX_W-1:0]        hostQ,
  input logic                     cpuAck,
  input logic                     hostAck,
  input logic [NUM_Q-1:0]         qEmpty,
  input logic [NUM_Q-1:0]         qFull,
  input logic [NUM_Q-1:0]         ovfFlag,
  input logic [NUM_Q*ADDR_W-1:0]  headPtrs,
  input logic [NUM_Q*ADDR_W-1:0]  tailPtrs,
  input logic [CODE_W:0]          ctrlWord
);
  logic runOn;
  assign runOn = ctrlWord[0] && (ctrlWord[CODE_W:1] != '0);

  assert_side_cpu_R11: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck |-> (cpuReq && (cpuPush == !cpuQ[0])));
  assert_side_host_R11: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> (hostReq && (hostPush == hostQ[0])));
  assert_disabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    !runOn |-> (!cpuAck && !hostAck));
  assert_pop_empty_cpu_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuPush && qEmpty[cpuQ]) |-> !cpuAck);
  assert_pop_empty_tail_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && !hostPush && qEmpty[hostQ] && !cpuReq && !cfgWrEn) |=> $stable(tailPtrs));
  assert_push_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && hostPush && qFull[hostQ]) |-> !hostAck);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrEn && cfgSel == SEL_CTRL) |=> ((ovfFlag & $past(ovfFlag)) == $past(ovfFlag)));
  assert_push_moves_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAck && cpuPush && !cfgWrEn) |=> !$stable(headPtrs));
endmodule

bind cq_pointer_mgr cq_pointer_mgr_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
  .cpuReq(cpuReq), .cpuPush(cpuPush), .cpuQ(cpuQ),
  .hostReq(hostReq), .hostPush(hostPush), .hostQ(hostQ),
  .cpuAck(cpuAck), .hostAck(hostAck), .qEmpty(qEmpty), .qFull(qFull),
  .ovfFlag(ovfFlag), .headPtrs(headPtrs), .tailPtrs(tailPtrs),
  .ctrlWord(ctrlWord)
);

// File: tb/cq_pointer_mgr_tb.sv
module cq_pointer_mgr_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [3:0]  cfgSel;
  logic [31:0] cfgWrData;
  logic        cpuReq, cpuPush, hostReq, hostPush;
  logic [1:0]  cpuQ, hostQ;
  logic        cpuAck, hostAck, postPending;
  logic [31:0] cpuAddr, hostAddr;
  logic [3:0]  qEmpty, qFull, ovfFlag;
  logic [127:0] headPtrs, tailPtrs;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    bit          hostSide;
    bit          ack;
    logic [31:0] addr;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #2 clk = ~clk;

  cq_pointer_mgr u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .cpuReq(cpuReq), .cpuPush(cpuPush), .cpuQ(cpuQ),
    .hostReq(hostReq), .hostPush(hostPush), .hostQ(hostQ),
    .cpuAck(cpuAck), .cpuAddr(cpuAddr), .hostAck(hostAck), .hostAddr(hostAddr),
    .qEmpty(qEmpty), .qFull(qFull), .ovfFlag(ovfFlag),
    .postPending(postPending), .headPtrs(headPtrs), .tailPtrs(tailPtrs)
  );

  function automatic logic [31:0] hd(int q);
    return headPtrs[q*32 +: 32];
  endfunction
  function automatic logic [31:0] tl(int q);
    return tailPtrs[q*32 +: 32];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares port results against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        exp_t e;
        logic        a;
        logic [31:0] ad;
        e  = expQ.pop_front();
        a  = e.hostSide ? hostAck  : cpuAck;
        ad = e.hostSide ? hostAddr : cpuAddr;
        chk({e.tag, " ack"}, {31'd0, a}, {31'd0, e.ack});
        if (e.ack) chk({e.tag, " addr"}, ad, e.addr);
      end
    end
  end

  task automatic issue(bit hostSide, bit push, logic [1:0] q, bit expAck,
                       logic [31:0] expAddr, string tag);
    exp_t e;
    @(negedge clk);
    if (hostSide) begin hostReq = 1'b1; hostPush = push; hostQ = q; end
    else          begin cpuReq  = 1'b1; cpuPush  = push; cpuQ  = q; end
    e.hostSide = hostSide; e.ack = expAck; e.addr = expAddr; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    cpuReq = 1'b0; hostReq = 1'b0;
    #1;
  endtask

  task automatic cfgWrite(logic [3:0] sel, logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
    #1;
  endtask

  localparam logic [31:0] BASE = 32'h1230_0000;
  localparam logic [31:0] SZ1  = 32'h0000_4000;

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgSel = '0; cfgWrData = '0;
    cpuReq = 1'b0; cpuPush = 1'b0; cpuQ = '0;
    hostReq = 1'b0; hostPush = 1'b0; hostQ = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 empty", {28'd0, qEmpty}, 32'hF);
    chk("R1 full", {28'd0, qFull}, 32'h0);
    chk("R1 ovf", {28'd0, ovfFlag}, 32'h0);
    chk("R1 pending", {31'd0, postPending}, 32'h0);
    chk("R1 head3", hd(3), 32'h0);

    // R2 base masked to 1 MB, pointers to window starts (size code 1)
    cfgWrite(4'd1, 32'h1234_5678);
    for (int q = 0; q < 4; q++) begin
      cfgWrite(4'(8 + q), BASE + 32'(q) * SZ1);
      cfgWrite(4'(12 + q), BASE + 32'(q) * SZ1);
    end
    chk("R12 head2 write", hd(2), BASE + 2 * SZ1);

    // R10 disabled block ignores requests
    issue(1'b0, 1'b1, 2'd0, 1'b0, 32'h0, "R10 disabled push");
    chk("R10 head0 unchanged", hd(0), BASE);

    cfgWrite(4'd0, 32'h3);

    // R4 push, R5 pop, R7 empty
    issue(1'b0, 1'b1, 2'd0, 1'b1, BASE, "R4 cpu push q0");
    chk("R4 head0 step", hd(0), BASE + 4);
    chk("R7 q0 not empty", {31'd0, qEmpty[0]}, 32'h0);
    issue(1'b1, 1'b0, 2'd0, 1'b1, BASE, "R5 host pop q0");
    chk("R5 tail0 step", tl(0), BASE + 4);
    chk("R7 q0 empty", {31'd0, qEmpty[0]}, 32'h1);

    // R9 pop of empty queue
    issue(1'b1, 1'b0, 2'd0, 1'b0, 32'h0, "R9 pop empty");
    chk("R9 tail0 unchanged", tl(0), BASE + 4);

    // R7 pending on inbound post queue
    issue(1'b1, 1'b1, 2'd1, 1'b1, BASE + SZ1, "R4 host push q1");
    chk("R7 pending set", {31'd0, postPending}, 32'h1);
    issue(1'b0, 1'b0, 2'd1, 1'b1, BASE + SZ1, "R5 cpu pop q1");
    chk("R7 pending clear", {31'd0, postPending}, 32'h0);

    // R11 wrong direction
    issue(1'b0, 1'b1, 2'd1, 1'b0, 32'h0, "R11 cpu push q1");
    chk("R11 head1 unchanged", hd(1), BASE + SZ1 + 4);
    issue(1'b1, 1'b1, 2'd0, 1'b0, 32'h0, "R11 host push q0");
    chk("R11 head0 unchanged", hd(0), BASE + 4);

    // R6 wrap at window end of q2
    cfgWrite(4'd10, BASE + 3 * SZ1 - 4);
    cfgWrite(4'd14, BASE + 3 * SZ1 - 4);
    issue(1'b0, 1'b1, 2'd2, 1'b1, BASE + 3 * SZ1 - 4, "R6 push last word");
    chk("R6 head2 wrap", hd(2), BASE + 2 * SZ1);
    issue(1'b1, 1'b0, 2'd2, 1'b1, BASE + 3 * SZ1 - 4, "R6 pop last word");
    chk("R6 tail2 wrap", tl(2), BASE + 2 * SZ1);

    // R8 full q3
    cfgWrite(4'd15, BASE + 3 * SZ1);
    cfgWrite(4'd11, BASE + 4 * SZ1 - 4);
    chk("R12 q3 full", {31'd0, qFull[3]}, 32'h1);
    issue(1'b1, 1'b1, 2'd3, 1'b0, 32'h0, "R8 push full");
    chk("R8 head3 unchanged", hd(3), BASE + 4 * SZ1 - 4);
    chk("R8 ovf3 set", {28'd0, ovfFlag}, 32'h8);
    issue(1'b0, 1'b0, 2'd3, 1'b1, BASE + 3 * SZ1, "R5 cpu pop q3");
    chk("R8 q3 not full", {31'd0, qFull[3]}, 32'h0);
    chk("R8 ovf sticky", {28'd0, ovfFlag}, 32'h8);
    cfgWrite(4'd0, 32'h3);
    chk("R8 ovf cleared", {28'd0, ovfFlag}, 32'h0);

    // R3 size code 2: q1 window is base+32K .. base+64K
    cfgWrite(4'd0, 32'h5);
    cfgWrite(4'd9, BASE + 32'h0000_FFFC);
    cfgWrite(4'd13, BASE + 32'h0000_FFFC);
    issue(1'b1, 1'b1, 2'd1, 1'b1, BASE + 32'h0000_FFFC, "R3 push q1 code2");
    chk("R3 head1 wrap code2", hd(1), BASE + 32'h0000_8000);

    // R10 size code 0 with enable set
    cfgWrite(4'd0, 32'h1);
    issue(1'b0, 1'b1, 2'd0, 1'b0, 32'h0, "R10 code zero");
    chk("R10 head0 code zero", hd(0), BASE + 4);

    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule